// File: doc/BRIEF.md
# Virtual Address Region Attribute Decoder

This block sits between a processor's address generation and its memory system. For each request it takes a 32-bit virtual address, the privilege of the access, the MMU enable, three cache control bits and the result of an external TLB lookup. The top three address bits select one of five fixed regions. The block then returns the physical address and the attributes of the access: whether it was translated, whether it may be cached, which write policy applies, and whether it targets on-chip I/O.

Two low regions, the low half and the region at 0xC0000000, are translated through the TLB while the MMU is on. The other regions are mapped directly by clearing the top three address bits, or are passed through unchanged as I/O space. A user-mode access above the low half is refused with an address error. A translated access that finds no TLB entry is reported as a miss. All results are registered and appear one clock after the request strobe.

Top module: `vaddr_region_decoder`

## Requirements
- R1: `rsp_valid` is high in the cycle after `req_valid` is sampled high, and low otherwise. All other outputs change only one cycle after a sampled request and hold their values between requests. After reset every output is 0.
- R2: Regions are decoded from address bits [31:29]. Values 000 to 011 select the low region, 100 selects the direct cached region, 101 the direct uncached region, 110 the upper translatable region, and 111 the I/O region.
- R3: In the low region and the upper translatable region with `mmu_en`=0, `rsp_paddr` is the address with bits [31:29] forced to 0. `rsp_translated` is 0 and `rsp_cacheable` equals `cache_en`.
- R4: In the low region and the upper translatable region with `mmu_en`=1 and `tlb_hit`=1, `rsp_translated` is 1 and `rsp_cacheable` is `cache_en` AND `tlb_cacheable`. With `tlb_page_large`=0 the physical address is {`tlb_ppn`, va[9:0]}. With `tlb_page_large`=1 it is {`tlb_ppn`[21:2], va[11:0]}.
- R5: In the low region and the upper translatable region, `rsp_writethru` (1 = write-through, 0 = copy-back) equals `wt_sel` when the access is cacheable. It is 0 when the access is not cacheable.
- R6: In the direct cached region, the physical address is the address with bits [31:29] cleared and `rsp_translated` is 0, whatever `mmu_en` and the TLB inputs are. `rsp_cacheable` equals `cache_en`, and `rsp_writethru` is the inverse of `cb_sel` (`cb_sel`=1 selects copy-back) when the access is cacheable.
- R7: In the direct uncached region, the physical address is the address with bits [31:29] cleared. `rsp_cacheable`, `rsp_translated` and `rsp_writethru` are 0.
- R8: In the I/O region, `rsp_paddr` equals the virtual address and `rsp_onchip_io` is 1. `rsp_cacheable`, `rsp_translated` and `rsp_writethru` are 0.
- R9: A translatable-region access with `mmu_en`=1 and `tlb_hit`=0 sets `rsp_tlb_miss`=1. `rsp_pa_valid` is 0, `rsp_paddr` is 0 and every other attribute is 0.
- R10: An access with `req_user`=1 and address bit 31 set gives `rsp_addr_err`=1. `rsp_pa_valid` is 0, `rsp_paddr` is 0 and every other attribute is 0. User accesses below 0x80000000 are handled normally.
- R11: `rsp_pa_valid` is 1 for every response that has neither a miss nor an address error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user-mode access |
| mmu_en | input | 1 | Address translation enable |
| cache_en | input | 1 | Global cache enable |
| wt_sel | input | 1 | Write-through select for the translatable regions |
| cb_sel | input | 1 | Copy-back select for the direct cached region |
| tlb_hit | input | 1 | TLB lookup found an entry |
| tlb_ppn | input | 22 | Physical page number, in 1 KB units |
| tlb_page_large | input | 1 | 1 = 4 KB page, 0 = 1 KB page |
| tlb_cacheable | input | 1 | Per-page cache bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_pa_valid | output | 1 | Physical address usable |
| rsp_translated | output | 1 | Address came from the TLB |
| rsp_cacheable | output | 1 | Access may be cached |
| rsp_writethru | output | 1 | 1 = write-through, 0 = copy-back |
| rsp_onchip_io | output | 1 | Target is on-chip I/O |
| rsp_tlb_miss | output | 1 | Translation needed but no entry |
| rsp_addr_err | output | 1 | Privilege violation |

## Verification
On every cycle the assertions check the following:
- the one-cycle response timing, and that outputs hold between requests;
- that a miss or an address error never comes with a usable address;
- that cached accesses never reach I/O;
- the user privilege rule, and the fixed behaviour of the direct uncached region.

The bench scenarios cover what depends on the exact data: the physical address formed from a page number for each page size, the choice between the two write-policy bits, the boundary addresses of each region, and the rule that the TLB inputs are ignored outside the translatable regions.

// File: rtl/vrd_pkg.sv
package vrd_pkg;
    localparam int VA_W      = 32;
    localparam int SEG_BITS  = 3;
    localparam int SMALL_OFS = 10;
    localparam int LARGE_OFS = 12;
    localparam int PPN_W     = VA_W - SMALL_OFS;

    typedef enum logic [2:0] {
        RGN_LOW = 3'd0,
        RGN_DC  = 3'd1,
        RGN_DU  = 3'd2,
        RGN_HI  = 3'd3,
        RGN_IO  = 3'd4
    } region_e;

    typedef struct packed {
        logic             hit;
        logic [PPN_W-1:0] ppn;
        logic             page_large;
        logic             cacheable;
    } tlb_res_t;

    typedef struct packed {
        logic            translated;
        logic            miss;
        logic [VA_W-1:0] paddr;
    } xlate_t;

    typedef struct packed {
        logic            pa_valid;
        logic            translated;
        logic            cacheable;
        logic            writethru;
        logic            onchip_io;
        logic            tlb_miss;
        logic            addr_err;
        logic [VA_W-1:0] paddr;
    } resp_t;

    function automatic region_e seg_to_region(input logic [SEG_BITS-1:0] seg);
        case (seg)
            3'b100:  return RGN_DC;
            3'b101:  return RGN_DU;
            3'b110:  return RGN_HI;
            3'b111:  return RGN_IO;
            default: return RGN_LOW;
        endcase
    endfunction

    function automatic logic [VA_W-1:0] strip_seg(input logic [VA_W-1:0] va);
        return {{SEG_BITS{1'b0}}, va[VA_W-SEG_BITS-1:0]};
    endfunction

    function automatic logic is_xlate_region(input region_e r);
        return (r == RGN_LOW) || (r == RGN_HI);
    endfunction
endpackage

// File: rtl/vrd_region_dec.sv
module vrd_region_dec
    import vrd_pkg::*;
#(
    parameter int AW = VA_W
) (
    input  logic [AW-1:0] vaddr,
    input  logic          user,
    output region_e       region,
    output logic          priv_err
);
    always_comb begin
        region   = seg_to_region(vaddr[AW-1 -: SEG_BITS]);
        priv_err = user && vaddr[AW-1];
    end
endmodule

// File: rtl/vrd_xlate.sv
module vrd_xlate
    import vrd_pkg::*;
#(
    parameter int AW     = VA_W,
    parameter int OFS_SM = SMALL_OFS,
    parameter int OFS_LG = LARGE_OFS
) (
    input  logic [AW-1:0] vaddr,
    input  region_e       region,
    input  logic          mmu_en,
    input  tlb_res_t      tlb,
    output xlate_t        xo
);
    localparam int PW  = AW - OFS_SM;
    localparam int GAP = OFS_LG - OFS_SM;

    logic [AW-1:0] pa_small;
    logic [AW-1:0] pa_large;
    logic          use_tlb;

    always_comb begin
        pa_small = {tlb.ppn, vaddr[OFS_SM-1:0]};
        pa_large = {tlb.ppn[PW-1:GAP], vaddr[OFS_LG-1:0]};
        use_tlb  = is_xlate_region(region) && mmu_en;

        xo = '0;
        if (region == RGN_IO) begin
            xo.paddr = vaddr;
        end else if (!use_tlb) begin
            xo.paddr = strip_seg(vaddr);
        end else if (tlb.hit) begin
            xo.translated = 1'b1;
            xo.paddr      = tlb.page_large ? pa_large : pa_small;
        end else begin
            xo.miss = 1'b1;
        end
    end
endmodule

// File: rtl/vrd_attr.sv
module vrd_attr
    import vrd_pkg::*;
(
    input  region_e region,
    input  logic    translated,
    input  logic    cache_en,
    input  logic    wt_sel,
    input  logic    cb_sel,
    input  logic    page_cacheable,
    output logic    cacheable,
    output logic    writethru,
    output logic    onchip_io
);
    always_comb begin
        cacheable = 1'b0;
        writethru = 1'b0;
        onchip_io = 1'b0;
        unique case (region)
            RGN_LOW, RGN_HI: begin
                cacheable = cache_en && (!translated || page_cacheable);
                writethru = cacheable && wt_sel;
            end
            RGN_DC: begin
                cacheable = cache_en;
                writethru = cache_en && !cb_sel;
            end
            RGN_IO: onchip_io = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/vaddr_region_decoder.sv
module vaddr_region_decoder
    import vrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_user,
    input  logic              mmu_en,
    input  logic              cache_en,
    input  logic              wt_sel,
    input  logic              cb_sel,
    input  logic              tlb_hit,
    input  logic [PPN_W-1:0]  tlb_ppn,
    input  logic              tlb_page_large,
    input  logic              tlb_cacheable,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic              rsp_pa_valid,
    output logic              rsp_translated,
    output logic              rsp_cacheable,
    output logic              rsp_writethru,
    output logic              rsp_onchip_io,
    output logic              rsp_tlb_miss,
    output logic              rsp_addr_err
);
    region_e  region;
    logic     priv_err;
    tlb_res_t tlb;
    xlate_t   xo;
    logic     a_cache;
    logic     a_wt;
    logic     a_io;
    resp_t    nxt;
    resp_t    cur;

    assign tlb = '{hit: tlb_hit, ppn: tlb_ppn, page_large: tlb_page_large,
                   cacheable: tlb_cacheable};

    vrd_region_dec #(.AW(VA_W)) u_rgn (
        .vaddr    (req_vaddr),
        .user     (req_user),
        .region   (region),
        .priv_err (priv_err)
    );

    vrd_xlate #(.AW(VA_W), .OFS_SM(SMALL_OFS), .OFS_LG(LARGE_OFS)) u_xl (
        .vaddr  (req_vaddr),
        .region (region),
        .mmu_en (mmu_en),
        .tlb    (tlb),
        .xo     (xo)
    );

    vrd_attr u_attr (
        .region         (region),
        .translated     (xo.translated),
        .cache_en       (cache_en),
        .wt_sel         (wt_sel),
        .cb_sel         (cb_sel),
        .page_cacheable (tlb_cacheable),
        .cacheable      (a_cache),
        .writethru      (a_wt),
        .onchip_io      (a_io)
    );

    always_comb begin
        nxt = '0;
        if (priv_err) begin
            nxt.addr_err = 1'b1;
        end else if (xo.miss) begin
            nxt.tlb_miss = 1'b1;
        end else begin
            nxt.pa_valid   = 1'b1;
            nxt.translated = xo.translated;
            nxt.cacheable  = a_cache;
            nxt.writethru  = a_wt;
            nxt.onchip_io  = a_io;
            nxt.paddr      = xo.paddr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) cur <= nxt;
        end
    end

    assign rsp_paddr      = cur.paddr;
    assign rsp_pa_valid   = cur.pa_valid;
    assign rsp_translated = cur.translated;
    assign rsp_cacheable  = cur.cacheable;
    assign rsp_writethru  = cur.writethru;
    assign rsp_onchip_io  = cur.onchip_io;
    assign rsp_tlb_miss   = cur.tlb_miss;
    assign rsp_addr_err   = cur.addr_err;
endmodule

// File: rtl/vrd_checker.sv
module vrd_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        req_user,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic        rsp_pa_valid,
    input logic        rsp_translated,
    input logic        rsp_cacheable,
    input logic        rsp_onchip_io,
    input logic        rsp_tlb_miss,
    input logic        rsp_addr_err
);
    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R1
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R1
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(rsp_paddr) && $stable(rsp_pa_valid) && $stable(rsp_cacheable)));
    // R9
    miss_no_pa_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_tlb_miss |-> (!rsp_pa_valid && rsp_paddr == 32'h0));
    // R10
    user_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_user && req_vaddr[31]) |=> (rsp_addr_err && !rsp_pa_valid));
    // R8
    io_uncached_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_onchip_io |-> (!rsp_cacheable && !rsp_translated));
    // R7
    du_region_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_user && req_vaddr[31:29] == 3'b101)
        |=> (rsp_pa_valid && !rsp_cacheable && rsp_paddr[31:29] == 3'b000));
    // R11
    pa_valid_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_pa_valid != (rsp_tlb_miss || rsp_addr_err)));
endmodule

bind vaddr_region_decoder vrd_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .req_user       (req_user),
    .rsp_valid      (rsp_valid),
    .rsp_paddr      (rsp_paddr),
    .rsp_pa_valid   (rsp_pa_valid),
    .rsp_translated (rsp_translated),
    .rsp_cacheable  (rsp_cacheable),
    .rsp_onchip_io  (rsp_onchip_io),
    .rsp_tlb_miss   (rsp_tlb_miss),
    .rsp_addr_err   (rsp_addr_err)
);

// File: tb/vaddr_region_decoder_tb.sv
module vaddr_region_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_user = 1'b0;
    logic        mmu_en = 1'b0;
    logic        cache_en = 1'b0;
    logic        wt_sel = 1'b0;
    logic        cb_sel = 1'b0;
    logic        tlb_hit = 1'b0;
    logic [21:0] tlb_ppn = '0;
    logic        tlb_page_large = 1'b0;
    logic        tlb_cacheable = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_pa_valid, rsp_translated, rsp_cacheable, rsp_writethru;
    logic        rsp_onchip_io, rsp_tlb_miss, rsp_addr_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    vaddr_region_decoder u_dut (.*);

    // flags order: pa_valid, translated, cacheable, writethru, onchip_io, tlb_miss, addr_err
    typedef struct packed {
        logic [31:0] va;
        logic        usr, mmu, ce, wt, cb, hit;
        logic [21:0] ppn;
        logic        big, tc;
        logic [31:0] e_pa;
        logic [6:0]  e_fl;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        // R3 R5 R2: top of low region, MMU off, write-through
        '{32'h7FFFF123, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 22'h0, 1'b0,1'b0, 32'h1FFFF123, 7'b1011000, 8'd3},
        // R3 R2: bottom of upper translatable region, cache off
        '{32'hC0000040, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 22'h0, 1'b0,1'b0, 32'h00000040, 7'b1000000, 8'd3},
        // R4 R5: 1 KB page, cached, copy-back
        '{32'h12345678, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 22'h2AAAAA, 1'b0,1'b1, 32'hAAAAAA78, 7'b1110000, 8'd4},
        // R4: 4 KB page, page bit clear makes it uncached
        '{32'hDEADBEEF, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b1, 22'h0F0F0F, 1'b1,1'b0, 32'h3C3C3EEF, 7'b1100000, 8'd4},
        // R4 R10: user access, 4 KB page, global cache off
        '{32'h00000FFF, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 22'h3FFFFF, 1'b1,1'b1, 32'hFFFFFFFF, 7'b1100000, 8'd4},
        // R9: translated access misses
        '{32'h40000000, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 22'h12345, 1'b0,1'b1, 32'h00000000, 7'b0000010, 8'd9},
        // R6 R2: start of direct cached region, copy-back via cb_sel
        '{32'h80000000, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 22'h3FFFFF, 1'b0,1'b0, 32'h00000000, 7'b1010000, 8'd6},
        // R6: end of direct cached region, MMU on without TLB hit, write-through
        '{32'h9FFFFFFC, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 22'h0, 1'b0,1'b0, 32'h1FFFFFFC, 7'b1011000, 8'd6},
        // R7: direct uncached region, cache enabled
        '{32'hA0001000, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 22'h1, 1'b0,1'b1, 32'h00001000, 7'b1000000, 8'd7},
        // R7 R2: end of direct uncached region
        '{32'hBFFFFFFF, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 22'h0, 1'b0,1'b0, 32'h1FFFFFFF, 7'b1000000, 8'd7},
        // R8 R2: start of I/O region
        '{32'hE0000000, 1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 22'h3, 1'b0,1'b1, 32'hE0000000, 7'b1000100, 8'd8},
        // R8: end of I/O region
        '{32'hFFFFFFFF, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 22'h0, 1'b0,1'b0, 32'hFFFFFFFF, 7'b1000100, 8'd8},
        // R10: user access at the first forbidden address
        '{32'h80000000, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b1, 22'h5, 1'b0,1'b1, 32'h00000000, 7'b0000001, 8'd10},
        // R10: user access to I/O region
        '{32'hFFFFFFFC, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 22'h5, 1'b1,1'b1, 32'h00000000, 7'b0000001, 8'd10},
        // R10 R3: user access at top of low region is allowed
        '{32'h7FFFFFFF, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 22'h0, 1'b0,1'b0, 32'h1FFFFFFF, 7'b1010000, 8'd10},
        // R3 R5 R11: end of upper translatable region, MMU off
        '{32'hDFFFFFFF, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 22'h0, 1'b0,1'b0, 32'h1FFFFFFF, 7'b1011000, 8'd11}
    };

    function automatic logic [6:0] act_flags();
        return {rsp_pa_valid, rsp_translated, rsp_cacheable, rsp_writethru,
                rsp_onchip_io, rsp_tlb_miss, rsp_addr_err};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_vaddr = v.va;  req_user = v.usr; mmu_en = v.mmu; cache_en = v.ce;
        wt_sel = v.wt;     cb_sel = v.cb;    tlb_hit = v.hit; tlb_ppn = v.ppn;
        tlb_page_large = v.big; tlb_cacheable = v.tc;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        string tag;
        logic [31:0] last_pa;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", {31'd0, rsp_valid, rsp_paddr, 1'b0, act_flags()}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            tag = $sformatf("R%0d vec%0d", VECS[i].rq, i);
            check({tag, " valid"}, {63'd0, rsp_valid}, 64'd1);
            check({tag, " paddr"}, {32'd0, rsp_paddr}, {32'd0, VECS[i].e_pa});
            check({tag, " flags"}, {57'd0, act_flags()}, {57'd0, VECS[i].e_fl});
            @(negedge clk);
        end

        // R1: no request, inputs change, outputs hold
        last_pa = rsp_paddr;
        drive(VECS[2]);
        repeat (2) @(negedge clk);
        check("R1 hold valid", {63'd0, rsp_valid}, 64'd0);
        check("R1 hold paddr", {32'd0, rsp_paddr}, {32'd0, last_pa});
        check("R1 hold flags", {57'd0, act_flags()}, {57'd0, VECS[NV-1].e_fl});

        // R1: back-to-back requests
        drive(VECS[10]);
        req_valid = 1'b1;
        @(negedge clk);
        check("R1 b2b first", {32'd0, rsp_paddr}, {32'd0, VECS[10].e_pa});
        drive(VECS[5]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 b2b second", {57'd0, act_flags()}, {57'd0, VECS[5].e_fl});
        check("R1 b2b valid", {63'd0, rsp_valid}, 64'd1);
        @(negedge clk);
        check("R1 b2b end", {63'd0, rsp_valid}, 64'd0);

        // R1: reset mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset again", {31'd0, rsp_valid, rsp_paddr, 1'b0, act_flags()}, 64'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule